// File: doc/BRIEF.md
# Interrupt Configuration Error Tracker

This block keeps one error flag for each line in a bank of shared peripheral interrupts. When the configuration storage for a line reports an uncorrectable error, that line's flag is set. While the flag is set, the block drives safe values on the line's effective-configuration outputs, whatever the line's programmed fields hold: the line is disabled, in group 0, without the group modifier, and edge-triggered. Software clears the flag by writing 1 to it. That same clear returns the line's group, modifier, trigger and non-secure-access fields to zero.

Software reaches the block through a word-indexed register port that carries a secure qualifier. Register 0 is the global control word: the two group enables, a secure-owned permission bit, and a read-only write-pending flag. The error flag for interrupt ID N is bit N mod 32 of register 1 + N/32. The per-line configuration registers start at a base offset. A clear is refused while any group enable is set, and while the write-pending flag is high. The flag rises for a fixed number of cycles after a group-enable change. Once the enables are off and the flag has dropped, a repeated clear is accepted.

Top module: `cfg_err_tracker`

## Requirements
- R1: After reset, all error flags, configuration fields and control bits read 0. The write-pending flag is low.
- R2: A cycle with `err_valid` high and `err_id` = N sets error flag N. The flag reads as bit N%32 of register 1 + N/32 after the next clock edge.
- R3: While a line's error flag is set, its `eff_enable`, `eff_group`, `eff_grpmod` and `eff_level` bits are 0, whatever its stored fields say.
- R4: For an errored line, `ns_pend_ok` equals control bit 2. For any other line, `ns_pend_ok` is 1 exactly when the line's non-secure access field (bits 5:4 of its configuration register) is non-zero.
- R5: A non-secure read of an error register returns 0. Non-secure writes to an error register or to the control register have no effect.
- R6: An accepted secure write of 1 to a set error flag clears the flag. It also sets configuration bits 5:1 of that line to 0 (group bit 1, modifier bit 2, level bit 3, access bits 5:4) and keeps the enable bit 0.
- R7: Writing 0 to an error flag has no effect. Writing 1 to a flag that is not set changes neither the flag nor the line's configuration.
- R8: A secure control write that changes bits 1:0 (the group enables) holds the write-pending flag high for exactly RWP_CYCLES cycles. The flag is visible on the `rwp` port and as bit 31 of register 0.
- R9: A clear is refused while either group enable is set or the write-pending flag is high. Once both conditions are false, a repeated clear is accepted.
- R10: If an error and an accepted clear hit the same line in the same cycle, the flag stays set.
- R11: The configuration register for line N is at address CFG_BASE + N and is readable and writable from either side. A write is stored even while the line is errored, and reads back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Word address for read and write |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| secure | input | 1 | Access is from the secure side |
| rd_data | output | 32 | Combinational read data for `addr` |
| err_valid | input | 1 | Uncorrectable error report valid |
| err_id | input | ID_W | Interrupt ID of the reported error |
| eff_enable | output | NUM_LINES | Effective enable per line |
| eff_group | output | NUM_LINES | Effective group bit per line |
| eff_grpmod | output | NUM_LINES | Effective group modifier per line |
| eff_level | output | NUM_LINES | Effective trigger type per line (1 = level) |
| ns_pend_ok | output | NUM_LINES | Non-secure side may set the line pending |
| rwp | output | 1 | Write-pending flag after a group-enable change |

## Verification
A flag that is set when it should not be shows up one cycle after the offending edge. The line's effective enable drops, and so does any group or level bit it was driving. A lost flag shows up in the same cycle: the programmed settings leak through the effective outputs. A clear that is accepted when it should be refused shows on the next secure read as a zero flag. A configuration reset in the wrong place shows on the next read of that line's register. A write-pending counter with the wrong length changes the number of cycles `rwp` stays high, so counting those cycles exposes it.

// File: rtl/cfg_err_tracker.sv
module cfg_err_tracker #(
  parameter int NUM_LINES  = 64,
  parameter int ADDR_W     = 8,
  parameter int CFG_BASE   = 16,
  parameter int RWP_CYCLES = 4,
  localparam int NUM_BANKS = (NUM_LINES + 31) / 32,
  localparam int ID_W      = $clog2(NUM_LINES),
  localparam int RWP_W     = $clog2(RWP_CYCLES + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 wr_en,
  input  logic [31:0]          wr_data,
  input  logic                 secure,
  output logic [31:0]          rd_data,
  input  logic                 err_valid,
  input  logic [ID_W-1:0]      err_id,
  output logic [NUM_LINES-1:0] eff_enable,
  output logic [NUM_LINES-1:0] eff_group,
  output logic [NUM_LINES-1:0] eff_grpmod,
  output logic [NUM_LINES-1:0] eff_level,
  output logic [NUM_LINES-1:0] ns_pend_ok,
  output logic                 rwp
);

  logic [NUM_BANKS*32-1:0]     err_q;
  logic [NUM_LINES-1:0]        en_q, grp_q, mod_q, lvl_q;
  logic [NUM_LINES-1:0][1:0]   nsa_q;
  logic [1:0]                  grp_en_q;
  logic                        nspend_q;
  logic [RWP_W-1:0]            rwp_cnt;
  logic [NUM_LINES-1:0]        set_v, clr_v, cfg_v;
  logic [NUM_LINES-1:0]        err_l;

  wire ctl_wr = wr_en && secure && (addr == '0);
  wire clr_ok = (grp_en_q == 2'b00) && (rwp_cnt == '0);

  assign rwp   = (rwp_cnt != '0);
  assign err_l = err_q[NUM_LINES-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grp_en_q <= 2'b00;
      nspend_q <= 1'b0;
      rwp_cnt  <= '0;
    end else begin
      if (ctl_wr) begin
        grp_en_q <= wr_data[1:0];
        nspend_q <= wr_data[2];
      end
      if (ctl_wr && (wr_data[1:0] != grp_en_q))
        rwp_cnt <= RWP_W'(RWP_CYCLES);
      else if (rwp_cnt != '0)
        rwp_cnt <= rwp_cnt - 1'b1;
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_LINES; i++) begin
      set_v[i] = err_valid && (err_id == ID_W'(i));
      clr_v[i] = wr_en && secure && clr_ok && err_q[i] && wr_data[i % 32]
                 && (addr == ADDR_W'(1 + i / 32));
      cfg_v[i] = wr_en && (addr == ADDR_W'(CFG_BASE + i));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_q <= '0;
      en_q  <= '0;
      grp_q <= '0;
      mod_q <= '0;
      lvl_q <= '0;
      nsa_q <= '0;
    end else begin
      for (int i = 0; i < NUM_LINES; i++) begin
        if (set_v[i])      err_q[i] <= 1'b1;
        else if (clr_v[i]) err_q[i] <= 1'b0;
        if (cfg_v[i]) begin
          en_q[i]  <= wr_data[0];
          grp_q[i] <= wr_data[1];
          mod_q[i] <= wr_data[2];
          lvl_q[i] <= wr_data[3];
          nsa_q[i] <= wr_data[5:4];
        end else if (clr_v[i] && !set_v[i]) begin
          grp_q[i] <= 1'b0;
          mod_q[i] <= 1'b0;
          lvl_q[i] <= 1'b0;
          nsa_q[i] <= 2'b00;
        end
      end
    end
  end

  assign eff_enable = en_q  & ~err_l;
  assign eff_group  = grp_q & ~err_l;
  assign eff_grpmod = mod_q & ~err_l;
  assign eff_level  = lvl_q & ~err_l;

  always_comb begin
    for (int i = 0; i < NUM_LINES; i++)
      ns_pend_ok[i] = err_l[i] ? nspend_q : (nsa_q[i] != 2'b00);
  end

  always_comb begin
    rd_data = '0;
    if (addr == '0)
      rd_data = {rwp, 28'b0, nspend_q, grp_en_q};
    for (int b = 0; b < NUM_BANKS; b++)
      if (secure && addr == ADDR_W'(1 + b))
        rd_data = err_q[b*32 +: 32];
    for (int i = 0; i < NUM_LINES; i++)
      if (addr == ADDR_W'(CFG_BASE + i))
        rd_data = {26'b0, nsa_q[i], lvl_q[i], mod_q[i], grp_q[i], en_q[i]};
  end

endmodule

// File: rtl/cfg_err_tracker_chk.sv
module cfg_err_tracker_chk #(
  parameter int NUM_LINES = 64,
  parameter int ADDR_W    = 8,
  parameter int NUM_BANKS = 2,
  parameter int ID_W      = 6
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [ADDR_W-1:0]      addr,
  input logic                   wr_en,
  input logic                   secure,
  input logic [31:0]            rd_data,
  input logic                   err_valid,
  input logic [ID_W-1:0]        err_id,
  input logic [NUM_LINES-1:0]   eff_enable,
  input logic [NUM_LINES-1:0]   eff_group,
  input logic [NUM_LINES-1:0]   eff_level,
  input logic                   rwp,
  input logic [NUM_BANKS*32-1:0] err_q,
  input logic [1:0]             grp_en_q
);

  wire bank_addr = (addr >= ADDR_W'(1)) && (addr <= ADDR_W'(NUM_BANKS));
  wire id_ok     = (32'(err_id) < NUM_LINES);

  // R2 R10
  err_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_valid && id_ok) |=> err_q[$past(err_id)]);

  // R3
  err_safe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_valid && id_ok) |=> (!eff_enable[$past(err_id)] && !eff_group[$past(err_id)]
                              && !eff_level[$past(err_id)]));

  // R5
  ns_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!secure && bank_addr) |-> (rd_data == 32'b0));

  // R5
  ns_ctl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !secure && addr == '0) |=> $stable(grp_en_q));

  // R9
  refuse_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((rwp || grp_en_q != 2'b00) && !err_valid) |=> (err_q == $past(err_q)));

  // R8
  rwp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rwp && !(wr_en && secure && addr == '0)) |=> !rwp);

  // R8
  rwp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rwp) |=> rwp);

endmodule

bind cfg_err_tracker cfg_err_tracker_chk #(
  .NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS), .ID_W(ID_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .secure(secure),
  .rd_data(rd_data), .err_valid(err_valid), .err_id(err_id),
  .eff_enable(eff_enable), .eff_group(eff_group), .eff_level(eff_level),
  .rwp(rwp), .err_q(err_q), .grp_en_q(grp_en_q)
);

// File: tb/sim_cfg_err_tracker.sv
module sim_cfg_err_tracker;
  localparam int N = 64;
  localparam int AW = 8;
  localparam int CB = 16;

  logic          clk = 0, rst_n = 0;
  logic [AW-1:0] addr = '0;
  logic          wr_en = 0, secure = 0, err_valid = 0;
  logic [31:0]   wr_data = '0, rd_data;
  logic [5:0]    err_id = '0;
  logic [N-1:0]  eff_enable, eff_group, eff_grpmod, eff_level, ns_pend_ok;
  logic          rwp;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  cfg_err_tracker #(.NUM_LINES(N), .ADDR_W(AW), .CFG_BASE(CB), .RWP_CYCLES(4)) u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .secure(secure), .rd_data(rd_data), .err_valid(err_valid), .err_id(err_id),
    .eff_enable(eff_enable), .eff_group(eff_group), .eff_grpmod(eff_grpmod),
    .eff_level(eff_level), .ns_pend_ok(ns_pend_ok), .rwp(rwp));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d, input logic sec);
    @(negedge clk);
    addr = AW'(a); wr_data = d; secure = sec; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input int a, input logic sec, output logic [31:0] d);
    @(negedge clk);
    addr = AW'(a); secure = sec;
    #1 d = rd_data;
  endtask

  task automatic inject(input int id);
    @(negedge clk);
    err_id = 6'(id); err_valid = 1;
    @(negedge clk);
    err_valid = 0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(0, 1, d);  check("R1 ctl", d, 0);
    rd(1, 1, d);  check("R1 bank1", d, 0);
    rd(CB + 5, 1, d); check("R1 cfg", d, 0);
    check("R1 rwp", 32'(rwp), 0);
    check("R1 eff", 32'(eff_enable[31:0] | eff_group[31:0]), 0);
  endtask

  task automatic t_inject();
    logic [31:0] d;
    wr(CB + 5, 32'h1F, 0);
    check("R11 eff_en before error", 32'(eff_enable[5]), 1);
    check("R4 ns ok from field", 32'(ns_pend_ok[5]), 1);
    inject(5);
    check("R3 safe", {eff_enable[5], eff_group[5], eff_grpmod[5], eff_level[5]}, 0);
    check("R4 errored ns ok off", 32'(ns_pend_ok[5]), 0);
    rd(1, 1, d);  check("R2 bank1 bit5", d, 32'h20);
    rd(1, 0, d);  check("R5 ns read", d, 0);
    rd(CB + 5, 0, d); check("R11 cfg kept", d, 32'h1F);
    inject(40);
    rd(2, 1, d);  check("R2 bank2 bit8", d, 32'h100);
    wr(0, 32'h4, 1);
    check("R4 errored ns ok on", 32'(ns_pend_ok[5]), 1);
    check("R8 no rwp w/o group change", 32'(rwp), 0);
    wr(0, 32'h0, 1);
  endtask

  task automatic t_ignored();
    logic [31:0] d;
    wr(1, 32'h0, 1);
    rd(1, 1, d); check("R7 write0", d, 32'h20);
    wr(1, 32'h20, 0);
    rd(1, 1, d); check("R5 ns clear ignored", d, 32'h20);
    wr(0, 32'h3, 0);
    rd(0, 1, d); check("R5 ns ctl ignored", d, 0);
    wr(CB + 7, 32'h1E, 1);
    wr(1, 32'h80, 1);
    rd(CB + 7, 1, d); check("R7 unset cfg untouched", d, 32'h1E);
    rd(1, 1, d); check("R7 unset flag", d, 32'h20);
  endtask

  task automatic t_clear();
    logic [31:0] d;
    wr(1, 32'h20, 1);
    rd(1, 1, d); check("R6 flag cleared", d, 0);
    rd(CB + 5, 1, d); check("R6 fields reset", d, 32'h01);
    check("R6 eff_en", 32'(eff_enable[5]), 1);
  endtask

  task automatic t_rwp();
    logic [31:0] d;
    int hi;
    inject(9);
    wr(0, 32'h3, 1);
    hi = 0;
    for (int k = 0; k < 8; k++) begin
      if (rwp) hi++;
      if (k < 7) @(negedge clk);
    end
    check("R8 rwp length", hi, 4);
    wr(1, 32'h200, 1);
    rd(1, 1, d); check("R9 refused groups on", d, 32'h200);
    wr(0, 32'h0, 1);
    rd(0, 1, d); check("R8 rwp bit31", d, 32'h8000_0000);
    wr(1, 32'h200, 1);
    rd(1, 1, d); check("R9 refused rwp", d, 32'h200);
    repeat (5) @(negedge clk);
    wr(1, 32'h200, 1);
    rd(1, 1, d); check("R9 accepted", d, 0);
  endtask

  task automatic t_collide();
    logic [31:0] d;
    inject(12);
    @(negedge clk);
    addr = 1; wr_data = 32'h1000; secure = 1; wr_en = 1;
    err_id = 12; err_valid = 1;
    @(negedge clk);
    wr_en = 0; err_valid = 0;
    rd(1, 1, d); check("R10 error wins", d, 32'h1000);
    wr(CB + 12, 32'h0F, 1);
    rd(CB + 12, 1, d); check("R11 write while errored", d, 32'h0F);
    check("R3 overridden", 32'(eff_enable[12]), 0);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_inject();
    t_ignored();
    t_clear();
    t_rwp();
    t_collide();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule